// File: doc/BRIEF.md
# Full-Duplex Pause Flow Control Unit

This unit handles both halves of link-level flow control for a byte-wide Ethernet MAC running in full duplex. When the local logic asks for the partner to stop, a single-cycle request that carries a 16-bit pause time makes the unit emit the body of a MAC control pause frame. The frame goes out on a valid/ready byte stream that feeds a downstream framer, and that framer adds padding and the FCS. The unit sends nothing unless the link is full duplex and both ends have advertised pause ability.

On the receive side the unit watches the incoming byte stream, which carries start and end markers. It matches the reserved control multicast address, the control EtherType and the pause opcode, and takes the 16-bit pause time from the frame. A received pause loads a countdown measured in pause quanta, with each quantum lasting a configurable number of clock cycles. While the countdown runs, the unit holds off the local transmitter through an inhibit output. It raises that output only between data frames and never while a data frame is in progress.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `tx_inhibit` and `ctl_tx_valid` are low.
- R2: A pause frame body is 18 bytes in this order: bytes 0-5 are the destination 0x01,0x80,0xC2,0x00,0x00,0x01; bytes 6-11 are `station_addr` with bits [47:40] first; bytes 12-13 are 0x88,0x08; bytes 14-15 are 0x00,0x01; bytes 16-17 are the pause time, high byte first. `ctl_tx_first` marks byte 0 and `ctl_tx_last` marks byte 17.
- R3: A `pause_req` starts a frame only if `full_duplex`, `local_pause_able` and `partner_pause_able` are all high and no frame is already in progress. Any other request is dropped, and a dropped request does not change a frame that is already being sent.
- R4: While `ctl_tx_valid` is high and `ctl_tx_ready` is low, the presented byte and its markers hold steady. A byte is consumed on a clock edge where both are high.
- R5: A received frame begins with a byte that carries `rx_sof`. It counts as a pause frame only if its bytes 0-5, 12-13 and 14-15 match the values listed in R2 and `rx_eof` arrives on byte 17 or later. Bytes 6-11 and any bytes after 17 are not checked. A frame that is too short or that mismatches has no effect.
- R6: A pause frame accepted with time T (nonzero) keeps `tx_inhibit` high for exactly T*QUANTUM_CYCLES cycles, starting in the cycle after the clock edge that takes in the end byte, provided `data_tx_busy` is low.
- R7: An accepted pause frame with time 0 ends any active pause at once. A new nonzero pause frame reloads the countdown from its own time.
- R8: When `full_duplex` is low, a received pause frame is ignored.
- R9: `tx_inhibit` does not rise while `data_tx_busy` is high. The countdown keeps running during that time. Once `tx_inhibit` is high, it stays high until the countdown expires, whatever `data_tx_busy` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Link is in full-duplex mode |
| local_pause_able | input | 1 | Local end advertised pause ability |
| partner_pause_able | input | 1 | Link partner advertised pause ability |
| station_addr | input | 48 | Source address placed in sent frames |
| pause_req | input | 1 | Single-cycle request to send a pause frame |
| pause_req_time | input | 16 | Pause time for the requested frame |
| ctl_tx_valid | output | 1 | Control frame byte is present |
| ctl_tx_ready | input | 1 | Downstream takes the byte |
| ctl_tx_data | output | 8 | Control frame byte |
| ctl_tx_first | output | 1 | Marks the first byte |
| ctl_tx_last | output | 1 | Marks the last byte |
| rx_valid | input | 1 | Receive byte is present |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Receive byte is the first of a frame |
| rx_eof | input | 1 | Receive byte is the last of a frame |
| data_tx_busy | input | 1 | The local transmitter is sending a data frame |
| tx_inhibit | output | 1 | Hold off the start of new data frames |

## Verification
The bench builds the unit with QUANTUM_CYCLES set to 3. This keeps every countdown short, so the bench can sweep pause times 1 through 6 against 0 to 2 trailing bytes and check each inhibit window to the exact cycle. With the small quantum, reloads, zero-time clears and data-busy deferrals also fit inside a few dozen cycles. The frame checks corrupt each matched header byte in turn, cut a frame off before the time field ends, and restart a frame in the middle. On the send side, several pause times and station addresses run under an irregular ready pattern, and the bench also tries each blocking link condition.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam int unsigned      FRAME_BYTES = 18;
  localparam logic [47:0]      CTRL_DEST   = 48'h0180_C200_0001;
  localparam logic [15:0]      CTRL_ETYPE  = 16'h8808;
  localparam logic [15:0]      OP_PAUSE    = 16'h0001;

  typedef struct packed {
    logic       care;
    logic [7:0] val;
  } hdr_expect_t;

  // Byte k (0 = most significant) of a 48-bit value.
  function automatic logic [7:0] addr_byte(logic [47:0] v, logic [2:0] k);
    logic [47:0] s;
    s = v >> (6'd8 * (6'd5 - {3'd0, k}));
    return s[7:0];
  endfunction

  // Content of byte idx in an outgoing pause frame body.
  function automatic logic [7:0] tx_frame_byte(logic [4:0] idx, logic [47:0] sa,
                                               logic [15:0] qt);
    logic [7:0] b;
    if (idx < 5'd6)       b = addr_byte(CTRL_DEST, idx[2:0]);
    else if (idx < 5'd12) b = addr_byte(sa, 3'(idx - 5'd6));
    else begin
      case (idx)
        5'd12:   b = CTRL_ETYPE[15:8];
        5'd13:   b = CTRL_ETYPE[7:0];
        5'd14:   b = OP_PAUSE[15:8];
        5'd15:   b = OP_PAUSE[7:0];
        5'd16:   b = qt[15:8];
        default: b = qt[7:0];
      endcase
    end
    return b;
  endfunction

  // Which received bytes must match, and against what.
  function automatic hdr_expect_t rx_expect(logic [4:0] idx);
    hdr_expect_t e;
    e.care = 1'b0;
    e.val  = 8'h00;
    if (idx < 5'd6) begin
      e.care = 1'b1;
      e.val  = addr_byte(CTRL_DEST, idx[2:0]);
    end else if (idx >= 5'd12 && idx <= 5'd15) begin
      e.care = 1'b1;
      e.val  = tx_frame_byte(idx, 48'd0, 16'd0);
    end
    return e;
  endfunction

endpackage

// File: rtl/pfc_tx_builder.sv
module pfc_tx_builder
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        send_ok,
  input  logic [47:0] station_addr,
  input  logic        pause_req,
  input  logic [15:0] pause_req_time,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last
);

  localparam logic [4:0] LAST_IDX = 5'(FRAME_BYTES - 1);

  logic        busy_q;
  logic [4:0]  idx_q;
  logic [15:0] time_q;
  logic [47:0] sa_q;

  // Internal events brought out for the assertions.
  logic start_evt, beat_evt, done_evt;
  assign start_evt = !busy_q && pause_req && send_ok;
  assign beat_evt  = busy_q && tx_ready;
  assign done_evt  = beat_evt && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      time_q <= '0;
      sa_q   <= '0;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      time_q <= pause_req_time;
      sa_q   <= station_addr;
    end else if (beat_evt) begin
      if (done_evt) busy_q <= 1'b0;
      else          idx_q  <= idx_q + 5'd1;
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = busy_q ? tx_frame_byte(idx_q, sa_q, time_q) : 8'h00;
  assign tx_first = busy_q && (idx_q == 5'd0);
  assign tx_last  = busy_q && (idx_q == LAST_IDX);

  a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  a_r3_start_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(send_ok));

  a_r2_first_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> tx_first);

  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tx_ready) |=> !tx_valid);

endmodule

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  output logic        pause_hit,
  output logic [15:0] pause_time
);

  localparam logic [4:0] TIME_HI_IDX = 5'(FRAME_BYTES - 2);
  localparam logic [4:0] TIME_LO_IDX = 5'(FRAME_BYTES - 1);

  logic [4:0]  idx_q;
  logic        match_q;
  logic [7:0]  hi_q, lo_q;

  logic [4:0]  idx_now;
  hdr_expect_t exp_now;
  logic        match_now;

  assign idx_now   = rx_sof ? 5'd0 : idx_q;
  assign exp_now   = rx_expect(idx_now);
  assign match_now = (rx_sof || match_q) && (!exp_now.care || (rx_data == exp_now.val));

  assign pause_hit  = rx_valid && rx_eof && match_now && (idx_now >= TIME_LO_IDX);
  assign pause_time = (idx_now == TIME_LO_IDX) ? {hi_q, rx_data} : {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      match_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (rx_valid) begin
      if (idx_now <= TIME_LO_IDX) idx_q <= idx_now + 5'd1;
      match_q <= match_now && !rx_eof;
      if (idx_now == TIME_HI_IDX) hi_q <= rx_data;
      if (idx_now == TIME_LO_IDX) lo_q <= rx_data;
    end
  end

  a_r5_no_single_byte_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |-> !rx_sof);

  a_r5_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof) |=> !match_q);

endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
  parameter int unsigned QUANTUM_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] load_time,
  input  logic        data_busy,
  output logic        pause_active,
  output logic        tx_inhibit
);

  localparam int unsigned QW = (QUANTUM_CYCLES > 1) ? $clog2(QUANTUM_CYCLES) : 1;
  localparam logic [QW-1:0] SUB_MAX = QW'(QUANTUM_CYCLES - 1);

  logic [15:0]   quanta_q;
  logic [QW-1:0] sub_q;
  logic          held_q;

  // Internal event: one whole quantum has elapsed.
  logic quantum_tick;
  assign quantum_tick = (quanta_q != 16'd0) && (sub_q == '0);
  assign pause_active = (quanta_q != 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quanta_q <= '0;
      sub_q    <= '0;
    end else if (load) begin
      quanta_q <= load_time;
      sub_q    <= SUB_MAX;
    end else if (quantum_tick) begin
      quanta_q <= quanta_q - 16'd1;
      sub_q    <= SUB_MAX;
    end else if (pause_active) begin
      sub_q    <= sub_q - QW'(1);
    end
  end

  // The inhibit starts only while no data frame is in progress, then holds.
  assign tx_inhibit = pause_active && (held_q || !data_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= tx_inhibit;
  end

  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_time == 16'd0) |=> !pause_active);

  a_r6_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_time != 16'd0) |=> pause_active);

  a_r9_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_inhibit) |-> !data_busy);

  a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_inhibit && !quantum_tick && !load) |=> tx_inhibit);

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && quantum_tick) |=> (quanta_q == $past(quanta_q) - 16'd1));

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int unsigned QUANTUM_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        full_duplex,
  input  logic        local_pause_able,
  input  logic        partner_pause_able,
  input  logic [47:0] station_addr,
  input  logic        pause_req,
  input  logic [15:0] pause_req_time,
  output logic        ctl_tx_valid,
  input  logic        ctl_tx_ready,
  output logic [7:0]  ctl_tx_data,
  output logic        ctl_tx_first,
  output logic        ctl_tx_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        data_tx_busy,
  output logic        tx_inhibit
);

  logic        send_ok;
  logic        rx_pause_hit;
  logic [15:0] rx_pause_time;
  logic        timer_load;
  logic        pause_active;

  assign send_ok    = full_duplex && local_pause_able && partner_pause_able;
  assign timer_load = rx_pause_hit && full_duplex;

  pfc_tx_builder u_tx (
    .clk            (clk),
    .rst_n          (rst_n),
    .send_ok        (send_ok),
    .station_addr   (station_addr),
    .pause_req      (pause_req),
    .pause_req_time (pause_req_time),
    .tx_valid       (ctl_tx_valid),
    .tx_ready       (ctl_tx_ready),
    .tx_data        (ctl_tx_data),
    .tx_first       (ctl_tx_first),
    .tx_last        (ctl_tx_last)
  );

  pfc_rx_parser u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_sof     (rx_sof),
    .rx_eof     (rx_eof),
    .pause_hit  (rx_pause_hit),
    .pause_time (rx_pause_time)
  );

  pfc_pause_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (timer_load),
    .load_time    (rx_pause_time),
    .data_busy    (data_tx_busy),
    .pause_active (pause_active),
    .tx_inhibit   (tx_inhibit)
  );

  a_r8_half_duplex_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !pause_active) |=> !pause_active);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!ctl_tx_valid && !pause_active));

endmodule

// File: tb/pause_flow_ctrl_tb.sv
module pause_flow_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_duplex, local_pause_able, partner_pause_able;
  logic [47:0] station_addr;
  logic        pause_req;
  logic [15:0] pause_req_time;
  logic        ctl_tx_valid, ctl_tx_ready, ctl_tx_first, ctl_tx_last;
  logic [7:0]  ctl_tx_data;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        data_tx_busy;
  logic        tx_inhibit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [7:0] fr [0:31];
  int         fr_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_flow_ctrl #(.QUANTUM_CYCLES(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .local_pause_able(local_pause_able), .partner_pause_able(partner_pause_able),
    .station_addr(station_addr), .pause_req(pause_req), .pause_req_time(pause_req_time),
    .ctl_tx_valid(ctl_tx_valid), .ctl_tx_ready(ctl_tx_ready), .ctl_tx_data(ctl_tx_data),
    .ctl_tx_first(ctl_tx_first), .ctl_tx_last(ctl_tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .data_tx_busy(data_tx_busy), .tx_inhibit(tx_inhibit)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Expected outgoing byte, computed from R2 by shifting.
  function automatic logic [7:0] exp_tx(int i, logic [47:0] sa, logic [15:0] t);
    logic [143:0] whole;
    whole = {48'h0180C2000001, sa, 16'h8808, 16'h0001, t};
    return whole[143 - 8*i -: 8];
  endfunction

  task automatic build_pause(input logic [15:0] t, input int extra);
    for (int i = 0; i < 18; i++) fr[i] = exp_tx(i, 48'h5A0000000000 + 48'(i * 7 + t), t);
    for (int i = 0; i < extra; i++) fr[18 + i] = 8'(8'hC3 + i);
    fr_len = 18 + extra;
  endtask

  task automatic send_frame();
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fr[i];
      rx_sof = (i == 0); rx_eof = (i == fr_len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
    #1;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (tx_inhibit && n < 400) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic request(input logic [15:0] t);
    @(negedge clk); pause_req = 1'b1; pause_req_time = t;
    @(negedge clk); pause_req = 1'b0;
  endtask

  task automatic collect_check(input logic [47:0] sa, input logic [15:0] t, input int seed);
    int n = 0;
    int guard = 0;
    while (n < 18 && guard < 200) begin
      if (guard != 0) @(negedge clk);
      ctl_tx_ready = ((guard + seed) % 3) != 1;
      #1;
      if (ctl_tx_valid && ctl_tx_ready) begin
        check(ctl_tx_data == exp_tx(n, sa, t), "R2 byte", ctl_tx_data, exp_tx(n, sa, t));
        check(ctl_tx_first == (n == 0) && ctl_tx_last == (n == 17), "R2 markers",
              {ctl_tx_first, ctl_tx_last}, {n == 0, n == 17});
        n++;
      end
      guard++;
    end
    check(n == 18, "R4 byte count", n, 18);
    @(negedge clk); ctl_tx_ready = 1'b0; #1;
    check(!ctl_tx_valid, "R2 frame ends", ctl_tx_valid, 0);
  endtask

  initial begin
    int n;
    logic [15:0] tl [0:4];
    rst_n = 1'b0; full_duplex = 1'b1; local_pause_able = 1'b1; partner_pause_able = 1'b1;
    station_addr = 48'h0A1B2C3D4E5F; pause_req = 1'b0; pause_req_time = 16'h0;
    ctl_tx_ready = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h0;
    data_tx_busy = 1'b0;
    idle(3);
    rst_n = 1'b1;
    #1;
    check(!tx_inhibit && !ctl_tx_valid, "R1 reset", {tx_inhibit, ctl_tx_valid}, 0);

    // R2/R4: several pause times and addresses, irregular ready.
    tl[0] = 16'h0000; tl[1] = 16'h0001; tl[2] = 16'h1234; tl[3] = 16'hFFFF; tl[4] = 16'hA55A;
    for (int k = 0; k < 5; k++) begin
      station_addr = 48'h0A1B2C3D4E5F ^ {8'(k * 17), 40'(k * 40'h0303030303)};
      request(tl[k]);
      collect_check(station_addr, tl[k], k);
    end

    // R3: a second request during a frame is dropped.
    station_addr = 48'h665544332211;
    request(16'h0BEE);
    ctl_tx_ready = 1'b0;
    request(16'hDEAD);
    collect_check(48'h665544332211, 16'h0BEE, 2);

    // R3: each blocking link condition.
    for (int k = 0; k < 3; k++) begin
      full_duplex = (k != 0); local_pause_able = (k != 1); partner_pause_able = (k != 2);
      ctl_tx_ready = 1'b1;
      request(16'h0042);
      n = 0;
      for (int c = 0; c < 20; c++) begin @(negedge clk); #1; if (ctl_tx_valid) n++; end
      check(n == 0, "R3 blocked", n, 0);
    end
    full_duplex = 1'b1; local_pause_able = 1'b1; partner_pause_able = 1'b1;
    ctl_tx_ready = 1'b0;

    // R6: sweep pause times and trailing bytes.
    for (int t = 1; t <= 6; t++) begin
      for (int e = 0; e <= 2; e++) begin
        build_pause(16'(t), e);
        send_frame();
        measure(n);
        check(n == t * Q, "R6 window", n, t * Q);
      end
    end

    // R5: corrupt each matched header byte.
    for (int p = 0; p < 16; p++) begin
      if (p >= 6 && p < 12) continue;
      build_pause(16'd4, 0);
      fr[p] = fr[p] ^ 8'h10;
      send_frame();
      check(!tx_inhibit, "R5 mismatch ignored", tx_inhibit, 0);
      idle(2);
    end

    // R5: frame ends before the pause time is complete.
    build_pause(16'd4, 0);
    fr_len = 17;
    send_frame();
    check(!tx_inhibit, "R5 short frame", tx_inhibit, 0);

    // R5: restart mid-frame with a new start marker.
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i * 9); rx_sof = (i == 0); rx_eof = 1'b0;
    end
    build_pause(16'd2, 1);
    send_frame();
    measure(n);
    check(n == 2 * Q, "R5 restart", n, 2 * Q);

    // R7: zero clears, new frame reloads.
    build_pause(16'd50, 0);
    send_frame();
    idle(3);
    build_pause(16'd0, 0);
    send_frame();
    check(!tx_inhibit, "R7 zero clears", tx_inhibit, 0);
    build_pause(16'd50, 0);
    send_frame();
    idle(5);
    build_pause(16'd2, 0);
    send_frame();
    measure(n);
    check(n == 2 * Q, "R7 reload", n, 2 * Q);

    // R8: half duplex ignores received pause.
    full_duplex = 1'b0;
    build_pause(16'd3, 0);
    send_frame();
    n = 0;
    for (int c = 0; c < 10; c++) begin if (tx_inhibit) n++; @(negedge clk); #1; end
    check(n == 0, "R8 half duplex", n, 0);
    full_duplex = 1'b1;

    // R9: deferred while busy, then held regardless of busy.
    data_tx_busy = 1'b1;
    build_pause(16'd4, 0);
    send_frame();
    n = 0;
    for (int c = 0; c < 3; c++) begin if (tx_inhibit) n++; if (c < 2) begin @(negedge clk); #1; end end
    check(n == 0, "R9 deferred", n, 0);
    @(negedge clk); data_tx_busy = 1'b0; #1;
    check(tx_inhibit, "R9 rises after busy", tx_inhibit, 1);
    @(negedge clk); data_tx_busy = 1'b1; #1;
    n = 1;
    while (tx_inhibit && n < 100) begin n++; @(negedge clk); #1; end
    check(n == 4 * Q - 3, "R9 held", n, 4 * Q - 3);
    data_tx_busy = 1'b0;

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule